// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a parameterised chain of boundary scan cells that sits between the core logic and the device pins. There is one cell for every device input and one for every device output. Each cell has a shift stage, which takes part in capture and shift, and a separate update latch that holds a test value. A mode code and three strobes (capture, shift, update) arrive from an external TAP controller and instruction decoder. The chain clock is TCK and the reset is the test-logic reset, which is synchronous and active high.

The mode code decides whether the pins and the core see functional data or the values held in the update latches. Because of this one code, a single chain serves six modes: functional pass-through, sampling of live values, preloading test values, driving the board (external test), driving the core (internal test), and clamping the outputs. Serial data enters at `tdi_i`. The cell nearest `tdi_i` is input cell 0. The input cells come next in index order, then the output cells, and the last output cell drives `tdo_o`.

Top module: `bscan_chain`

## Requirements
- R1: The mode code is 0 for functional and 1 for sample. It is 2 for preload, 3 for external test, 4 for internal test and 5 for clamp. Codes 6 and 7 act as functional. The code sampled at a TCK rising edge governs the pins, the core and the strobes from the next cycle onward.
- R2: In functional mode `pin_out_o` equals `core_out_i` and `core_in_o` equals `pin_in_i` at all times. The capture, shift and update strobes leave every shift stage and update latch unchanged.
- R3: A test-logic reset returns the block to functional mode on the next cycle. It does not alter any shift stage or update latch.
- R4: In a shift cycle, stage 0 takes `tdi_i` and every stage k takes stage k-1. `tdo_o` always shows the last stage. Stages 0 to N_IN-1 are input cells and the stages above them are output cells.
- R5: On capture, input cells load `pin_in_i`. Output cells load the value on `pin_out_o` in sample and external-test modes, and load `core_out_i` in internal-test mode.
- R6: On update, each latch copies its own shift stage. The shift stages stay as they were.
- R7: In sample mode, captures, shifts and updates work, but the pins and the core keep seeing functional data.
- R8: In preload mode, shift and update work, and a capture strobe leaves the shift stages unchanged. The pins and the core keep seeing functional data.
- R9: In external-test mode, `pin_out_o` shows the output-cell latches and `core_in_o` follows `pin_in_i`. Latches filled earlier in preload mode appear on the pins without a further update.
- R10: In internal-test mode, `core_in_o` shows the input-cell latches and `pin_out_o` shows the output-cell latches.
- R11: In clamp mode, `pin_out_o` shows the output-cell latches and `core_in_o` follows `pin_in_i`. All three strobes leave the stages and latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock (TCK); all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high test-logic reset |
| mode_i | input | 3 | Mode code from the instruction decoder |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (last stage) |
| pin_in_i | input | N_IN | Values arriving at the input pins |
| core_in_o | output | N_IN | Values presented to the core inputs |
| core_out_i | input | N_OUT | Values produced by the core for the output pins |
| pin_out_o | output | N_OUT | Values driven onto the output pins |

## Verification
The bench sweeps every 8-bit pattern through a 4-input, 4-output chain in external-test mode. A chain with the wrong bit order or a missing stage would show the pattern on the wrong pins, or would shift back a rotated word. Preload followed by capture and a switch to external test catches two faults: a preload mode that captures, and latches lost when the mode changes. Strobes are applied in functional mode, in clamp mode and with the unused code 7, and the bench then reads back the stages and latches. This exposes a decoder that lets strobes through where they must be ignored. A reset issued during external test must release the pins at once and must also keep the latched pattern. A design that clears the chain on reset, or that drives the pins from the reset value of the mode, fails this check.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [2:0] {
    MODE_FUNC    = 3'd0,
    MODE_SAMPLE  = 3'd1,
    MODE_PRELOAD = 3'd2,
    MODE_EXTEST  = 3'd3,
    MODE_INTEST  = 3'd4,
    MODE_CLAMP   = 3'd5
  } bscan_mode_e;

  // Map a raw code onto a mode; unused codes fall back to functional.
  function automatic bscan_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return MODE_SAMPLE;
      3'd2:    return MODE_PRELOAD;
      3'd3:    return MODE_EXTEST;
      3'd4:    return MODE_INTEST;
      3'd5:    return MODE_CLAMP;
      default: return MODE_FUNC;
    endcase
  endfunction

endpackage

// File: rtl/bscan_mode_ctl.sv
module bscan_mode_ctl
  import bscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  mode_i,
  input  logic        capture_i,
  input  logic        shift_i,
  input  logic        update_i,
  output bscan_mode_e mode_q,
  output logic        cap_en,
  output logic        shift_en,
  output logic        upd_en,
  output logic        drive_pins,
  output logic        drive_core,
  output logic        out_cap_core
);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_FUNC;
    else     mode_q <= decode_mode(mode_i);
  end

  logic chain_live;
  logic cap_allowed;

  always_comb begin
    chain_live   = 1'b0;
    cap_allowed  = 1'b0;
    drive_pins   = 1'b0;
    drive_core   = 1'b0;
    out_cap_core = 1'b0;
    case (mode_q)
      MODE_SAMPLE: begin
        chain_live  = 1'b1;
        cap_allowed = 1'b1;
      end
      MODE_PRELOAD: begin
        chain_live  = 1'b1;
      end
      MODE_EXTEST: begin
        chain_live  = 1'b1;
        cap_allowed = 1'b1;
        drive_pins  = 1'b1;
      end
      MODE_INTEST: begin
        chain_live   = 1'b1;
        cap_allowed  = 1'b1;
        drive_pins   = 1'b1;
        drive_core   = 1'b1;
        out_cap_core = 1'b1;
      end
      MODE_CLAMP: begin
        drive_pins  = 1'b1;
      end
      default: begin
      end
    endcase
  end

  assign cap_en   = chain_live & cap_allowed & capture_i;
  assign shift_en = chain_live & shift_i & ~capture_i;
  assign upd_en   = chain_live & update_i;

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic cap_d,
  input  logic scan_in,
  output logic stage_q,
  output logic latch_q
);

  always_ff @(posedge clk) begin
    if (cap_en)        stage_q <= cap_d;
    else if (shift_en) stage_q <= scan_in;
  end

  always_ff @(posedge clk) begin
    if (upd_en) latch_q <= stage_q;
  end

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !shift_en) |=> $stable(stage_q));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(latch_q));

  // R6
  latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> (latch_q == $past(stage_q)));

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_i,
  input  logic             capture_i,
  input  logic             shift_i,
  input  logic             update_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [N_OUT-1:0] core_out_i,
  output logic [N_OUT-1:0] pin_out_o
);

  localparam int TOTAL = N_IN + N_OUT;

  bscan_mode_e mode_q;
  logic cap_en, shift_en, upd_en;
  logic drive_pins, drive_core, out_cap_core;

  logic [TOTAL-1:0] stage_q;
  logic [TOTAL-1:0] latch_q;
  logic [TOTAL-1:0] cap_d;
  logic [TOTAL-1:0] scan_in;

  bscan_mode_ctl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .capture_i    (capture_i),
    .shift_i      (shift_i),
    .update_i     (update_i),
    .mode_q       (mode_q),
    .cap_en       (cap_en),
    .shift_en     (shift_en),
    .upd_en       (upd_en),
    .drive_pins   (drive_pins),
    .drive_core   (drive_core),
    .out_cap_core (out_cap_core)
  );

  for (genvar k = 0; k < TOTAL; k++) begin : g_cell
    if (k == 0) begin : g_head
      assign scan_in[k] = tdi_i;
    end else begin : g_link
      assign scan_in[k] = stage_q[k-1];
    end

    if (k < N_IN) begin : g_in
      assign cap_d[k] = pin_in_i[k];
    end else begin : g_out
      assign cap_d[k] = out_cap_core ? core_out_i[k-N_IN] : pin_out_o[k-N_IN];
    end

    bscan_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .upd_en   (upd_en),
      .cap_d    (cap_d[k]),
      .scan_in  (scan_in[k]),
      .stage_q  (stage_q[k]),
      .latch_q  (latch_q[k])
    );
  end

  assign core_in_o = drive_core ? latch_q[N_IN-1:0]     : pin_in_i;
  assign pin_out_o = drive_pins ? latch_q[TOTAL-1:N_IN] : core_out_i;
  assign tdo_o     = stage_q[TOTAL-1];

  // R2
  func_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FUNC) |-> (pin_out_o == core_out_i && core_in_o == pin_in_i));

  // R3
  rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out_o == core_out_i && core_in_o == pin_in_i));

  // R4
  shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (stage_q[0] == $past(tdi_i)));

  // R4
  shift_exit_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (tdo_o == $past(stage_q[TOTAL-2])));

  // R7
  sample_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SAMPLE) |-> (pin_out_o == core_out_i && core_in_o == pin_in_i));

  // R10
  intest_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_INTEST) |-> (core_in_o == latch_q[N_IN-1:0]));

endmodule

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;

  localparam int NI  = 4;
  localparam int NO  = 4;
  localparam int TOT = NI + NO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic cap = 1'b0, sh = 1'b0, up = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] pin_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) u_bscan_chain (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .capture_i(cap), .shift_i(sh), .update_i(up), .tdi_i(tdi), .tdo_o(tdo),
    .pin_in_i(pin_in), .core_in_o(core_in), .core_out_i(core_out), .pin_out_o(pin_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_i = m;
    @(negedge clk);
  endtask

  task automatic scan(input logic [TOT-1:0] s, output logic [TOT-1:0] o);
    for (int k = 0; k < TOT; k++) begin
      o[TOT-1-k] = tdo;
      tdi = s[TOT-1-k];
      sh = 1'b1;
      @(negedge clk);
    end
    sh = 1'b0;
  endtask

  task automatic pulse_cap();
    cap = 1'b1; @(negedge clk); cap = 1'b0;
  endtask

  task automatic pulse_upd();
    up = 1'b1; @(negedge clk); up = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [TOT-1:0] got;
    logic [TOT-1:0] s;
    logic [NO-1:0]  lat;
    repeat (2) @(negedge clk);
    core_out = 4'h9; pin_in = 4'h6;
    @(negedge clk);
    rst = 1'b0;
    // R3 reset state is functional
    chk("R3 reset pins", pin_out, 4'h9);
    chk("R3 reset core", core_in, 4'h6);

    // R2 transparency sweep
    for (int v = 0; v < 16; v++) begin
      core_out = v[3:0]; pin_in = ~v[3:0];
      #1;
      chk("R2 pass pins", pin_out, v & 15);
      chk("R2 pass core", core_in, (~v) & 15);
    end

    // R9 R6 R5 R4 external-test sweep over all patterns
    set_mode(3'd3);
    for (int p = 0; p < 256; p++) begin
      s = p[TOT-1:0];
      scan(s, got);
      pulse_upd();
      chk("R9 extest pins", pin_out, s[TOT-1:NI]);
      pin_in = s[NI-1:0] ^ 4'hA;
      #1;
      chk("R9 extest core follows pin", core_in, s[NI-1:0] ^ 4'hA);
      pulse_cap();
      scan('0, got);
      chk("R5 R4 extest capture", got, {s[TOT-1:NI], s[NI-1:0] ^ 4'hA});
    end

    // R6 update keeps stages
    s = 8'hC5;
    scan(s, got);
    pulse_upd();
    scan('0, got);
    chk("R6 stage kept after update", got, 8'hC5);

    // R7 sample
    set_mode(3'd1);
    core_out = 4'h3; pin_in = 4'hE;
    scan(8'h5A, got);
    pulse_upd();
    chk("R7 sample pins", pin_out, 4'h3);
    chk("R7 sample core", core_in, 4'hE);
    pulse_cap();
    scan('0, got);
    chk("R5 sample capture", got, {4'h3, 4'hE});

    // R8 preload then R9 extest applies without update
    set_mode(3'd2);
    core_out = 4'h1;
    scan(8'hB7, got);
    pulse_upd();
    chk("R8 preload pins", pin_out, 4'h1);
    pin_in = 4'h0;
    pulse_cap();
    scan(8'hB7, got);
    chk("R8 preload capture ignored", got, 8'hB7);
    set_mode(3'd3);
    chk("R9 preloaded value on pins", pin_out, 4'hB);

    // R2 strobes ignored in functional mode
    set_mode(3'd0);
    tdi = 1'b0;
    pulse_cap(); scan(8'h00, got); pulse_upd();
    set_mode(3'd3);
    chk("R2 latches kept in func", pin_out, 4'hB);
    scan(8'h00, got);
    chk("R2 stages kept in func", got, 8'hB7);

    // R10 internal test
    set_mode(3'd4);
    scan(8'h2D, got);
    pulse_upd();
    chk("R10 intest core", core_in, 4'hD);
    chk("R10 intest pins", pin_out, 4'h2);
    core_out = 4'h8; pin_in = 4'h5;
    pulse_cap();
    scan(8'h6C, got);
    chk("R5 intest capture", got, {4'h8, 4'h5});
    pulse_upd();

    // R11 clamp
    set_mode(3'd5);
    chk("R11 clamp pins", pin_out, 4'h6);
    chk("R11 clamp core", core_in, 4'h5);
    pulse_cap(); scan(8'h00, got); pulse_upd();
    set_mode(3'd3);
    chk("R11 latches kept in clamp", pin_out, 4'h6);
    scan(8'h00, got);
    chk("R11 stages kept in clamp", got, 8'h6C);

    // R1 unused code acts as functional; mode takes effect one edge later
    scan(8'h9F, got);
    pulse_upd();
    lat = 4'h9;
    mode_i = 3'd7;
    #1;
    chk("R1 old mode until edge", pin_out, lat);
    @(negedge clk);
    chk("R1 code 7 functional", pin_out, core_out);
    pulse_cap(); scan(8'h00, got); pulse_upd();
    set_mode(3'd3);
    chk("R1 code 7 strobes ignored", pin_out, lat);

    // R3 reset keeps chain contents
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R3 reset releases pins", pin_out, core_out);
    @(negedge clk);
    chk("R3 latches survive reset", pin_out, lat);
    scan(8'h00, got);
    chk("R3 stages survive reset", got, 8'h9F);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule